// File: doc/BRIEF.md
# Delayed-Error Adaptive Weight Updater

This block keeps the coefficient bank of an N-tap adaptive transversal filter and refreshes every coefficient in a single clock when a strobe is raised. It uses the least-mean-square rule with a delayed error: new weight = old weight + (step · error) · sample. The caller supplies the error that the filter produced several samples earlier, together with the input vector from that same instant, so the two stay aligned. The step size is always a negative power of two, so it is applied only as an arithmetic right shift of the error.

Each tap forms its product without a general multiplier. The sample is split into two-bit digits. Each digit selects one of 0, e, 2e or 3e, and a shift-add tree sums the selections. The top digit is read as signed and selects 0, e, -2e or -e. The multiple 3e is formed once and shared by every digit of every tap. The product is scaled back to weight units and added to the old weight, with saturation. The registered weights drive the filter's error path directly.

Top module: `dlms_wupd`

## Requirements
- R1: A synchronous active-high reset clears every weight to zero on the next rising edge.
- R2: While the update strobe is low, no weight changes, whatever the error, shift and sample inputs carry.
- R3: The scaled error is the EW-bit two's-complement error arithmetically right-shifted by the shift input, which is read as unsigned. This rounds toward minus infinity.
- R4: The tap product equals the exact signed product of the scaled error and the tap's L-bit two's-complement sample. Tap i's sample sits in bits [i*L +: L] of the sample bus.
- R5: When the strobe is high at a rising edge, each tap's weight becomes old + floor(product / 2^(L-1)). Tap i's weight appears in bits [i*W +: W] of the weight bus directly after that edge.
- R6: A sum above 2^(W-1)-1 stores exactly 2^(W-1)-1.
- R7: A sum below -2^(W-1) stores exactly -2^(W-1).
- R8: All taps update on the same edge, each from its own sample. Saturation on one tap leaves the others unaffected.
- R9: The block is driven by a system-identification loop with an adaptation delay of two samples and a shift of 2. Identifying a fixed four-tap unknown filter, the mean squared error over the last 200 of 1500 samples falls below 2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update strobe |
| err_dly | input | EW | Delayed error, two's complement |
| mu_sh | input | SW | Step-size shift (step = 2^-mu_sh) |
| x_dly | input | N*L | Delayed sample vector, tap i at [i*L +: L] |
| w_o | output | N*W | Registered weights, tap i at [i*W +: W] |

## Verification
One update can drive one tap into positive saturation, another into negative saturation, and leave the rest on the ordinary scaled sum, all in the same cycle. The bench provokes this with the largest error magnitude, a zero shift, and a sample vector that mixes +127, -128, 0 and 1. It judges each tap on its own against a bench model, and also against the explicit limit values. Random strobed updates cover the same overlap by chance, with every tap checked after every edge.

// File: rtl/dlms_pkg.sv
package dlms_pkg;
  typedef enum logic [1:0] {
    DG_ZERO  = 2'd0,
    DG_ONE   = 2'd1,
    DG_TWO   = 2'd2,
    DG_THREE = 2'd3
  } digit_e;
endpackage

// File: rtl/dlms_ppg.sv
module dlms_ppg #(
  parameter int L   = 8,
  parameter int MW  = 20,
  parameter int PRW = 26
) (
  input  logic signed [MW-1:0]  m1,
  input  logic signed [MW-1:0]  m3,
  input  logic        [L-1:0]   x,
  output logic signed [PRW-1:0] prod
);
  import dlms_pkg::*;
  localparam int ND = L / 2;

  logic signed [MW-1:0] pp [ND];

  for (genvar k = 0; k < ND; k++) begin : g_dig
    digit_e dg;
    assign dg = digit_e'(x[2*k+1:2*k]);
    if (k == ND - 1) begin : g_msd
      always_comb begin
        unique case (dg)
          DG_ONE:   pp[k] = m1;
          DG_TWO:   pp[k] = -(m1 <<< 1);
          DG_THREE: pp[k] = -m1;
          default:  pp[k] = '0;
        endcase
      end
    end else begin : g_lsd
      always_comb begin
        unique case (dg)
          DG_ONE:   pp[k] = m1;
          DG_TWO:   pp[k] = m1 <<< 1;
          DG_THREE: pp[k] = m3;
          default:  pp[k] = '0;
        endcase
      end
    end
  end

  always_comb begin
    prod = '0;
    for (int k = 0; k < ND; k++) begin
      prod = prod + (PRW'(pp[k]) <<< (2 * k));
    end
  end
endmodule

// File: rtl/dlms_tap.sv
module dlms_tap #(
  parameter int L  = 8,
  parameter int W  = 16,
  parameter int MW = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic signed [MW-1:0] m1,
  input  logic signed [MW-1:0] m3,
  input  logic        [L-1:0]  x,
  output logic signed [W-1:0]  w_q
);
  localparam int PRW  = MW + L - 2;
  localparam int SUMW = PRW + 1;
  localparam logic signed [SUMW-1:0] WMAX = SUMW'(2 ** (W - 1) - 1);
  localparam logic signed [SUMW-1:0] WMIN = -WMAX - SUMW'(1);

  logic signed [PRW-1:0]  prod;
  logic signed [PRW-1:0]  inc;
  logic signed [SUMW-1:0] sum;
  logic signed [W-1:0]    nxt;

  dlms_ppg #(.L(L), .MW(MW), .PRW(PRW)) u_ppg (
    .m1(m1), .m3(m3), .x(x), .prod(prod)
  );

  assign inc = prod >>> (L - 1);
  assign sum = SUMW'(w_q) + SUMW'(inc);

  always_comb begin
    if (sum > WMAX)      nxt = WMAX[W-1:0];
    else if (sum < WMIN) nxt = WMIN[W-1:0];
    else                 nxt = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      w_q <= '0;
    else if (upd) w_q <= nxt;
  end

  logic signed [PRW-1:0] ref_p;
  assign ref_p = PRW'(m1) * PRW'($signed(x));

  p_digit_product_r4: assert property (@(posedge clk) disable iff (rst)
    prod == ref_p);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(w_q));
  p_step_up_r5: assert property (@(posedge clk) disable iff (rst)
    (upd && !inc[PRW-1]) |=> (w_q >= $past(w_q)));
  p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
    (upd && inc[PRW-1]) |=> (w_q <= $past(w_q)));
  p_clip_high_r6: assert property (@(posedge clk) disable iff (rst)
    (upd && sum > WMAX) |=> (w_q == WMAX[W-1:0]));
  p_clip_low_r7: assert property (@(posedge clk) disable iff (rst)
    (upd && sum < WMIN) |=> (w_q == WMIN[W-1:0]));
endmodule

// File: rtl/dlms_wupd.sv
module dlms_wupd #(
  parameter int N  = 4,
  parameter int L  = 8,
  parameter int W  = 16,
  parameter int EW = 18,
  parameter int SW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_en,
  input  logic signed [EW-1:0] err_dly,
  input  logic        [SW-1:0] mu_sh,
  input  logic        [N*L-1:0] x_dly,
  output logic        [N*W-1:0] w_o
);
  localparam int MW = EW + 2;

  logic signed [EW-1:0] se;
  logic signed [MW-1:0] se1;
  logic signed [MW-1:0] se3;

  assign se  = err_dly >>> mu_sh;
  assign se1 = MW'(se);
  assign se3 = (se1 <<< 1) + se1;

  for (genvar g = 0; g < N; g++) begin : g_tap
    logic signed [W-1:0] wq;
    dlms_tap #(.L(L), .W(W), .MW(MW)) u_tap (
      .clk(clk), .rst(rst), .upd(upd_en),
      .m1(se1), .m3(se3), .x(x_dly[g*L +: L]), .w_q(wq)
    );
    assign w_o[g*W +: W] = wq;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (w_o == '0));
  p_zero_err_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_en && se == '0) |=> $stable(w_o));
endmodule

// File: tb/dlms_wupd_test.sv
module dlms_wupd_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int L  = 8;
  localparam int W  = 16;
  localparam int EW = 18;
  localparam int SW = 3;
  localparam longint WMAX = (64'sd1 <<< (W - 1)) - 1;
  localparam longint WMIN = -(64'sd1 <<< (W - 1));
  localparam longint EMAX = (64'sd1 <<< (EW - 1)) - 1;
  localparam longint EMIN = -(64'sd1 <<< (EW - 1));
  localparam int NS = 1500;
  localparam int MD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_en = 1'b0;
  logic signed [EW-1:0] err_dly = '0;
  logic [SW-1:0] mu_sh = '0;
  logic [N*L-1:0] x_dly = '0;
  logic [N*W-1:0] w_o;

  int checks = 0;
  int errors = 0;
  longint mw [N];

  dlms_wupd #(.N(N), .L(L), .W(W), .EW(EW), .SW(SW)) uut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .err_dly(err_dly),
    .mu_sh(mu_sh), .x_dly(x_dly), .w_o(w_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired act running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic longint wout(int i);
    logic signed [W-1:0] v;
    v = w_o[i*W +: W];
    return longint'(v);
  endfunction

  function automatic longint xat(logic [N*L-1:0] xs, int i);
    logic signed [L-1:0] v;
    v = xs[i*L +: L];
    return longint'(v);
  endfunction

  function automatic longint next_w(longint w, longint e, int sh, longint x);
    longint se, s;
    se = e >>> sh;
    s = w + ((se * x) >>> (L - 1));
    if (s > WMAX) s = WMAX;
    if (s < WMIN) s = WMIN;
    return s;
  endfunction

  function automatic longint rnd_s(int bits);
    longint r;
    r = longint'($urandom % (32'd1 << bits));
    return r - (64'sd1 <<< (bits - 1));
  endfunction

  function automatic logic [N*L-1:0] rnd_vec();
    logic [N*L-1:0] v;
    for (int i = 0; i < N; i++) v[i*L +: L] = L'(rnd_s(L));
    return v;
  endfunction

  task automatic check_eq(string tag, int tap, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s tap %0d act %0d exp %0d", tag, tap, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < N; i++) check_eq(tag, i, wout(i), mw[i]);
  endtask

  task automatic apply(string tag, logic v, longint e, int sh, logic [N*L-1:0] xs);
    @(negedge clk);
    upd_en = v; err_dly = EW'(e); mu_sh = SW'(sh); x_dly = xs;
    if (v) for (int i = 0; i < N; i++) mw[i] = next_w(mw[i], e, sh, xat(xs, i));
    @(posedge clk);
    @(negedge clk);
    upd_en = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1'b1; upd_en = 1'b1; err_dly = EW'(EMAX); x_dly = rnd_vec();
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; upd_en = 1'b0;
    for (int i = 0; i < N; i++) mw[i] = 0;
    check_all(tag);
  endtask

  longint h [N] = '{6000, -3000, 1500, -700};
  longint ebuf [NS];
  logic [N*L-1:0] xbuf [NS];

  initial begin
    logic [N*L-1:0] xs;
    longint xline [N];
    longint acc, d, y, e;
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) mw[i] = 0;

    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    // R5: plain update with moderate values
    xs = {8'sd10, -8'sd20, 8'sd64, 8'sd1};
    apply("R5 basic", 1'b1, 64'sd5000, 0, xs);

    // R2: strobe low with large inputs leaves weights alone
    apply("R2 idle", 1'b0, EMAX, 0, {8'sd127, 8'sd127, 8'sd127, 8'sd127});
    apply("R2 idle neg", 1'b0, EMIN, 7, {-8'sd128, 8'sd5, -8'sd3, 8'sd99});

    // R3: negative error with shifts round toward minus infinity
    apply("R3 shift1", 1'b1, -64'sd5, 1, {8'sd1, -8'sd1, 8'sd127, -8'sd128});
    apply("R3 shift7", 1'b1, -64'sd1000, 7, {8'sd127, -8'sd128, 8'sd3, -8'sd3});

    // R4: signed top digit values 1, -2 and -1 in the sample
    apply("R4 msd", 1'b1, 64'sd30000, 0, {8'sh40, 8'sh80, 8'shC0, 8'sh7F});

    // R6 R7 R8: mixed saturation in one cycle
    do_reset("R1 reset mid");
    xs = {8'sd1, 8'sd0, -8'sd128, 8'sd127};
    apply("R8 mixed sat", 1'b1, EMAX, 0, xs);
    check_eq("R6 high limit", 0, wout(0), WMAX);
    check_eq("R7 low limit", 1, wout(1), WMIN);
    apply("R6 R7 hold at limit", 1'b1, EMAX, 0, xs);
    apply("R8 swing", 1'b1, EMIN, 0, xs);
    check_eq("R6 swing to high", 1, wout(1), WMAX);
    check_eq("R7 swing to low", 0, wout(0), WMIN);

    // R3 R4 R5: random updates with random strobe
    for (int t = 0; t < 400; t++) begin
      apply("R5 random", 1'($urandom % 4 != 0), rnd_s(EW), int'($urandom % 8), rnd_vec());
    end

    // R9: system identification with delayed error
    do_reset("R1 reset sysid");
    for (int i = 0; i < N; i++) xline[i] = 0;
    acc = 0;
    for (int n = 0; n < NS; n++) begin
      for (int i = N - 1; i > 0; i--) xline[i] = xline[i-1];
      xline[0] = rnd_s(L);
      d = 0; y = 0;
      for (int i = 0; i < N; i++) begin
        d += h[i] * xline[i];
        y += wout(i) * xline[i];
        xs[i*L +: L] = L'(xline[i]);
      end
      e = (d >>> (L - 1)) - (y >>> (L - 1));
      if (e > EMAX) e = EMAX;
      if (e < EMIN) e = EMIN;
      ebuf[n] = e;
      xbuf[n] = xs;
      if (n >= NS - 200) acc += e * e;
      if (n >= MD) apply("R9 track", 1'b1, ebuf[n-MD], 2, xbuf[n-MD]);
      else apply("R9 track", 1'b0, 0, 2, xs);
    end
    checks++;
    if (acc / 200 >= 2000) begin
      errors++;
      $display("FAIL R9 mse act %0d exp below 2000", acc / 200);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule